// File: doc/BRIEF.md
# Bit-Serial Signed and Unsigned Comparator

This block compares two operands that are fed to it one bit per clock, lowest bit first. Each accepted cycle carries one bit of operand A and one bit of operand B, and a qualifier says whether that cycle holds a bit. On the cycle after a bit is taken, the outputs give the comparison of all bits accepted since the last clear. The signed result treats the bit just taken as the sign bit. The caller never has to declare a word length. The stream may stop after any bit, and the outputs are then the answer for that width.

A start strobe begins a new comparison. The state machine has four states. `ST_EMPTY` means no bit has been taken since the clear. `ST_EQUAL` means every bit so far has matched. `ST_BELOW` means A is unsigned-smaller at the current width. `ST_ABOVE` means A is unsigned-larger. The transitions are named as follows:
- CLEAR goes to `ST_EMPTY` on start or reset.
- TIE: a matching bit moves `ST_EMPTY` to `ST_EQUAL`, and leaves every other state in place.
- LOWER goes to `ST_BELOW` when A's bit is 0 and B's bit is 1.
- HIGHER goes to `ST_ABOVE` when A's bit is 1 and B's bit is 0.
- HOLD keeps the state when no bit is presented.

A separate sign flag stores the signed result. Greater-than outputs are decoded from the stored results, so they need no extra state.

Top module: `bsc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to the cleared condition: eq_o=1, ult_o=0, slt_o=0, ugt_o=0, sgt_o=0.
- R2: `start_i` clears the comparison. With `valid_i` low, the outputs become the cleared values on the next cycle. With `valid_i` high, the bit of that cycle is taken as bit 0 of a fresh comparison.
- R3: When `valid_i` and `start_i` are both low, all outputs keep their values.
- R4: eq_o is 1 exactly when every bit pair accepted since the last clear has matched. Once it is 0, it stays 0 until a clear.
- R5: ult_o follows this rule for each accepted pair: new = (!a & b) | ((a == b) & old), where old is 0 after a clear. It equals unsigned A < B over the accepted prefix.
- R6: slt_o for the newest accepted pair is a_i if the two bits differ, and otherwise the unsigned less-than of the earlier bits. It equals signed A < B, with the newest bit as the sign.
- R7: ugt_o = !ult_o & !eq_o and sgt_o = !slt_o & !eq_o.
- R8: A bit taken at a rising edge changes the outputs only after that edge. Before that edge, the outputs still show the previous prefix.
- R9: There is no width limit. A prefix of any length, including lengths past 100 bits, gives correct results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clear; begins a new comparison |
| valid_i | input | 1 | This cycle carries a bit pair |
| a_i | input | 1 | Current bit of operand A |
| b_i | input | 1 | Current bit of operand B |
| eq_o | output | 1 | Prefixes equal |
| ult_o | output | 1 | A < B unsigned |
| slt_o | output | 1 | A < B signed, newest bit as sign |
| ugt_o | output | 1 | A > B unsigned |
| sgt_o | output | 1 | A > B signed |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge, and that `start_i` and `valid_i` have settled before the edge. The stimulus changes inputs only one time unit after a rising edge, and it never drives an unknown value. The sequences cover long runs of equal bits, late differing bits, differences at the top bit, gaps with no valid bit, and a start on the same cycle as a valid bit.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_EQUAL = 2'd1,
        ST_BELOW = 2'd2,
        ST_ABOVE = 2'd3
    } cmp_state_e;
endpackage

// File: rtl/bsc_next.sv
module bsc_next
    import bsc_pkg::*;
(
    input  cmp_state_e cur_st,
    input  logic       cur_slt,
    input  logic       clr,
    input  logic       vld,
    input  logic       bit_a,
    input  logic       bit_b,
    output cmp_state_e nxt_st,
    output logic       nxt_slt
);
    cmp_state_e base_st;
    logic       base_slt;

    always_comb begin
        base_st  = clr ? ST_EMPTY : cur_st;
        base_slt = clr ? 1'b0 : cur_slt;
        nxt_st   = base_st;
        nxt_slt  = base_slt;
        if (vld) begin
            unique case ({bit_a, bit_b})
                2'b01: begin
                    nxt_st  = ST_BELOW;   // LOWER
                    nxt_slt = 1'b0;
                end
                2'b10: begin
                    nxt_st  = ST_ABOVE;   // HIGHER
                    nxt_slt = 1'b1;
                end
                default: begin            // TIE
                    nxt_st  = (base_st == ST_EMPTY) ? ST_EQUAL : base_st;
                    nxt_slt = (base_st == ST_BELOW);
                end
            endcase
        end
    end
endmodule

// File: rtl/bsc_decode.sv
module bsc_decode
    import bsc_pkg::*;
(
    input  cmp_state_e st,
    input  logic       slt_q,
    output logic       eq,
    output logic       ult,
    output logic       slt,
    output logic       ugt,
    output logic       sgt
);
    always_comb begin
        unique case (st)
            ST_EMPTY: begin eq = 1'b1; ult = 1'b0; end
            ST_EQUAL: begin eq = 1'b1; ult = 1'b0; end
            ST_BELOW: begin eq = 1'b0; ult = 1'b1; end
            ST_ABOVE: begin eq = 1'b0; ult = 1'b0; end
            default:  begin eq = 1'b1; ult = 1'b0; end
        endcase
        slt = slt_q;
        ugt = ~ult & ~eq;
        sgt = ~slt_q & ~eq;
    end
endmodule

// File: rtl/bsc_core.sv
module bsc_core
    import bsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic valid_i,
    input  logic a_i,
    input  logic b_i,
    output logic eq_o,
    output logic ult_o,
    output logic slt_o,
    output logic ugt_o,
    output logic sgt_o
);
    cmp_state_e state_q, state_d;
    logic       slt_q, slt_d;

    bsc_next u_next (
        .cur_st  (state_q),
        .cur_slt (slt_q),
        .clr     (start_i),
        .vld     (valid_i),
        .bit_a   (a_i),
        .bit_b   (b_i),
        .nxt_st  (state_d),
        .nxt_slt (slt_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            slt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            slt_q   <= slt_d;
        end
    end

    // outputs
    bsc_decode u_dec (
        .st    (state_q),
        .slt_q (slt_q),
        .eq    (eq_o),
        .ult   (ult_o),
        .slt   (slt_o),
        .ugt   (ugt_o),
        .sgt   (sgt_o)
    );
endmodule

// File: rtl/bsc_core_chk.sv
module bsc_core_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic valid_i,
    input logic a_i,
    input logic b_i,
    input logic eq_o,
    input logic ult_o,
    input logic slt_o,
    input logic ugt_o,
    input logic sgt_o
);
    // R2
    clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !valid_i) |=> (eq_o && !ult_o && !slt_o));

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !valid_i) |=> $stable({eq_o, ult_o, slt_o, ugt_o, sgt_o}));

    // R4
    eq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!eq_o && !start_i) |=> !eq_o);

    // R4
    eq_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (a_i != b_i)) |=> !eq_o);

    // R5
    ult_lower_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !a_i && b_i) |=> (ult_o && !slt_o));

    // R6
    slt_higher_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && a_i && !b_i) |=> (slt_o && !ult_o));

    // R7
    order_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({eq_o, ult_o, ugt_o}) && $onehot0({eq_o, slt_o, sgt_o}));
endmodule

bind bsc_core bsc_core_chk u_chk (.*);

// File: tb/bsc_core_test.sv
module bsc_core_test;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, valid_i = 1'b0, a_i = 1'b0, b_i = 1'b0;
    logic eq_o, ult_o, slt_o, ugt_o, sgt_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit qa[$];
    bit qb[$];

    always #(PERIOD/2) clk = ~clk;

    bsc_core uut (
        .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
        .a_i(a_i), .b_i(b_i), .eq_o(eq_o), .ult_o(ult_o), .slt_o(slt_o),
        .ugt_o(ugt_o), .sgt_o(sgt_o)
    );

    // behavioural reference: scan from the top bit for the first difference
    function automatic void model(output bit e, output bit u, output bit s);
        int top;
        int n;
        top = -1;
        n = qa.size();
        for (int i = n - 1; i >= 0; i--) begin
            if (qa[i] != qb[i]) begin
                top = i;
                break;
            end
        end
        e = (top < 0);
        u = (top >= 0) && (qa[top] == 1'b0);
        if (top < 0)            s = 1'b0;
        else if (top == n - 1)  s = qa[top];
        else                    s = u;
    endfunction

    task automatic check(input string tag, input string nm, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b (prefix %0d bits)", tag, nm, act, exp, qa.size());
        end
    endtask

    task automatic check_all(input string tag);
        bit e, u, s;
        model(e, u, s);
        check({tag, "/R4"}, "eq", eq_o, e);
        check({tag, "/R5"}, "ult", ult_o, u);
        check({tag, "/R6"}, "slt", slt_o, s);
        check({tag, "/R7"}, "ugt", ugt_o, !u && !e);
        check({tag, "/R7"}, "sgt", sgt_o, !s && !e);
    endtask

    task automatic step(input string tag, input bit st, input bit v, input bit a, input bit b);
        bit e, u, s;
        start_i = st; valid_i = v; a_i = a; b_i = b;
        #2;
        model(e, u, s);
        // R8: nothing moves before the edge
        check("R8", "eq-pre", eq_o, e);
        check("R8", "slt-pre", slt_o, s);
        @(posedge clk);
        #1;
        if (st) begin
            qa.delete();
            qb.delete();
        end
        if (v) begin
            qa.push_back(a);
            qb.push_back(b);
        end
        check_all(tag);
        start_i = 0; valid_i = 0;
    endtask

    task automatic feed(input string tag, input logic [31:0] av, input logic [31:0] bv, input int n);
        step(tag, 1'b1, 1'b1, av[0], bv[0]);
        for (int i = 1; i < n; i++) step(tag, 1'b0, 1'b1, av[i], bv[i]);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check_all("R1");

        // R4 R5 R6 simple patterns (3 vs 3, 3 vs 5, 7 vs 2 over 4 bits)
        feed("R4", 32'h3, 32'h3, 4);
        feed("R5", 32'h3, 32'h5, 4);
        feed("R6", 32'h7, 32'h2, 4);
        // differences at the sign bit of various widths
        feed("R6", 32'h8, 32'h1, 4);
        feed("R6", 32'h1, 32'h9, 4);
        feed("R5", 32'hA5, 32'hA5, 8);

        // R3 holds with gaps
        step("R2", 1'b1, 1'b1, 1'b0, 1'b1);
        step("R3", 1'b0, 1'b0, 1'b1, 1'b0);
        step("R3", 1'b0, 1'b0, 1'b1, 1'b1);
        step("R3", 1'b0, 1'b1, 1'b1, 1'b1);
        step("R3", 1'b0, 1'b0, 1'b0, 1'b1);

        // R2 start without valid clears
        step("R2", 1'b0, 1'b1, 1'b1, 1'b0);
        step("R2", 1'b1, 1'b0, 1'b0, 1'b0);
        // R2 start with valid takes bit 0 of a new word
        step("R2", 1'b0, 1'b1, 1'b1, 1'b0);
        step("R2", 1'b1, 1'b1, 1'b0, 1'b0);
        step("R2", 1'b0, 1'b1, 1'b0, 1'b1);

        // R4 eq sticky after a late match run
        step("R4", 1'b1, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step("R4", 1'b0, 1'b1, 1'b1, 1'b1);

        // R9 long random streams with random gaps
        for (int w = 0; w < 4; w++) begin
            step("R9", 1'b1, 1'b0, 1'b0, 1'b0);
            for (int i = 0; i < 150; i++) begin
                bit ab, bb, vb;
                ab = 1'($urandom);
                bb = (w == 0) ? ab : 1'($urandom);
                if (w == 1 && ($urandom % 8) != 0) bb = ab;
                vb = (($urandom % 5) != 0);
                step("R9", 1'b0, vb, ab, bb);
            end
        end

        // R1 reset mid-stream
        step("R1", 1'b0, 1'b1, 1'b1, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        qa.delete();
        qb.delete();
        check_all("R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule